// File: doc/BRIEF.md
# Coprocessor Host Command and Status Interface

This block sits between a host processor's programmed-I/O instructions and an arithmetic coprocessor core that shares the host's memory. Each I/O instruction arrives for one cycle with a device code, a 3-bit operation and the host accumulator. For its main device code the block loads a 12-bit command word and a 15-bit start pointer (3 high bits plus 12 low bits). It launches, resumes, force-stops and clears the core, and it answers with a skip flag and a 12-bit status word.

The core reports each exit with a one-cycle event that carries the exit causes. The block latches those causes as sticky flags and raises an internal interrupt request. The flags stay set until the host reads and acknowledges them with the skip-and-read operation. A second device code carries a single operation that switches the core to its wide-precision mode. A command load, a clear or a reset ends that mode.

Top module: `fpx_host_if`

## Requirements
- R1: After reset, and in the cycle after operation 2 on the main device (which also gives a one-cycle `reset_o` pulse), the following are all zero: command, pointer, flags, interrupt request, pending forced exit and wide mode.
- R2: Operation 1 on the main device asserts `skip_o` combinationally when the interrupt request is set, and only then.
- R3: Operation 3 loads `cmd_o` from `ac_i` and `ptr_hi_o` from `ac_i[2:0]` when `core_run_i` is low and no interrupt request is pending. It also clears wide mode. In any other state it has no effect.
- R4: Operation 5 with the core idle and no request pending loads `ptr_lo_o` from `ac_i`, asserts `skip_o`, and gives a one-cycle `start_o` pulse in the following cycle.
- R5: Operation 5 with `core_run_i` and `core_pause_i` both high asserts `skip_o` and gives a one-cycle `resume_o` pulse in the following cycle. In every other state it neither skips nor pulses.
- R6: Operation 4 sets `fexit_req_o`, which stays high until the next core exit event. At that exit the forced-exit flag is set if a request was pending. The flag is cleared instead if `exit_by_instr_i` marks the exit as a normal exit instruction.
- R7: A core exit event sets the interrupt request. It ORs `exit_cause_i` into the sticky flags: bit0 trap, bit1 divide by zero, bit2 fraction overflow, bit3 exponent overflow, bit4 underflow.
- R8: `status_o` bits are as follows:
  - 11: running
  - 10: running and paused
  - 9: wide mode
  - 8:7: zero
  - 6: underflow
  - 5: exponent overflow
  - 4: fraction overflow
  - 3: divide by zero
  - 2: forced exit
  - 1: trap
  - 0: `cmd_o[2]` (fixed-point mode)

  Operation 6 asserts `rd_o` in any state.
- R9: Operation 7 with the interrupt request set asserts `skip_o` and `rd_o` and shows the status as it was before the clear. It clears the flags and the request in the next cycle. With no request pending it does nothing.
- R10: Operation 7 on the auxiliary device sets wide mode, and gives an `ac_clr_o` pulse in the next cycle, only under three conditions: `ac_i` is octal 4000, `core_run_i` is low, and the option is fitted.
- R11: `host_int_o` is high exactly when `cmd_o[3]` and the interrupt request are both set.
- R12: Instructions for any other device code, or with operation 0, produce no skip, no read and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iot_valid_i | input | 1 | I/O instruction present this cycle |
| iot_dev_i | input | 6 | Device code |
| iot_op_i | input | 3 | Operation bits |
| ac_i | input | 12 | Host accumulator |
| core_run_i | input | 1 | Core running |
| core_pause_i | input | 1 | Core paused |
| core_exit_i | input | 1 | Core exit event, one cycle |
| exit_cause_i | input | 5 | Exit causes (R7 bit order) |
| exit_by_instr_i | input | 1 | Exit came from a normal exit instruction |
| skip_o | output | 1 | Host skip |
| rd_o | output | 1 | Status word is being returned |
| status_o | output | 12 | Status word |
| ac_clr_o | output | 1 | Clear host accumulator pulse |
| cmd_o | output | 12 | Command register |
| ptr_hi_o | output | 3 | High pointer bits |
| ptr_lo_o | output | 12 | Low pointer bits |
| ext_mode_o | output | 1 | Wide-precision mode |
| start_o | output | 1 | Start pulse to core |
| resume_o | output | 1 | Resume pulse to core |
| reset_o | output | 1 | Reset pulse to core |
| fexit_req_o | output | 1 | Forced exit pending |
| host_int_o | output | 1 | Host interrupt |

## Verification
A stuck or lost interrupt request is the most damaging internal fault. It shows at the ports on the very next instruction: operations 1 and 7 skip wrongly, `host_int_o` follows it, and command or start loads are refused. Flag corruption shows as a wrong status word on the next read. A wrong gate on loads shows one cycle later as a changed `cmd_o` or `ptr_lo_o`, or as a missing start pulse. Random instruction streams are interleaved with exit events and run/pause changes, so that every gate is exercised in every core state.

// File: rtl/fhi_pkg.sv
package fhi_pkg;
  localparam int unsigned FLAG_W   = 6;
  localparam int unsigned CAUSE_W  = 5;
  localparam int unsigned FIX_BIT  = 2;
  localparam int unsigned INTE_BIT = 3;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_SKIP_IRQ  = 3'd1,
    OP_CLEAR     = 3'd2,
    OP_LOAD_CMD  = 3'd3,
    OP_FORCE_EX  = 3'd4,
    OP_START     = 3'd5,
    OP_READ      = 3'd6,
    OP_SKIP_READ = 3'd7
  } hop_e;

  typedef struct packed {
    logic skip_irq;
    logic clear;
    logic load_cmd;
    logic force_exit;
    logic start;
    logic read;
    logic skip_read;
    logic ext_sel;
  } hop_hits_t;
endpackage

// File: rtl/fhi_decode.sv
module fhi_decode
  import fhi_pkg::*;
#(
  parameter int unsigned DEV_W    = 6,
  parameter logic [DEV_W-1:0] DEV_MAIN = 6'o55,
  parameter logic [DEV_W-1:0] DEV_AUX  = 6'o56
) (
  input  logic             valid_i,
  input  logic [DEV_W-1:0] dev_i,
  input  logic [2:0]       op_i,
  output hop_hits_t        hits_o
);
  localparam int unsigned N_OP = 8;

  logic main_sel, aux_sel;
  logic [N_OP-1:0] op_hit;

  assign main_sel = valid_i && (dev_i == DEV_MAIN);
  assign aux_sel  = valid_i && (dev_i == DEV_AUX);

  for (genvar k = 0; k < N_OP; k++) begin : g_op
    assign op_hit[k] = main_sel && (op_i == k[2:0]);
  end

  always_comb begin
    hits_o            = '0;
    hits_o.skip_irq   = op_hit[OP_SKIP_IRQ];
    hits_o.clear      = op_hit[OP_CLEAR];
    hits_o.load_cmd   = op_hit[OP_LOAD_CMD];
    hits_o.force_exit = op_hit[OP_FORCE_EX];
    hits_o.start      = op_hit[OP_START];
    hits_o.read       = op_hit[OP_READ];
    hits_o.skip_read  = op_hit[OP_SKIP_READ];
    hits_o.ext_sel    = aux_sel && (op_i == OP_SKIP_READ);
  end
endmodule

// File: rtl/fhi_cmd_regs.sv
module fhi_cmd_regs
  import fhi_pkg::*;
#(
  parameter int unsigned W          = 12,
  parameter int unsigned HI_W       = 3,
  parameter bit          EXT_FITTED = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  hop_hits_t       hits_i,
  input  logic [W-1:0]    ac_i,
  input  logic            run_i,
  input  logic            pause_i,
  input  logic            irq_i,
  output logic [W-1:0]    cmd_o,
  output logic [HI_W-1:0] ptr_hi_o,
  output logic [W-1:0]    ptr_lo_o,
  output logic            ext_o,
  output logic            go_skip_o,
  output logic            start_o,
  output logic            resume_o,
  output logic            reset_o,
  output logic            ac_clr_o
);
  localparam logic [W-1:0] EXT_KEY = {1'b1, {(W-1){1'b0}}};

  logic acc_load, acc_start, acc_resume, acc_ext;

  assign acc_load   = hits_i.load_cmd && !run_i && !irq_i;
  assign acc_start  = hits_i.start && !run_i && !irq_i;
  assign acc_resume = hits_i.start && run_i && pause_i;
  assign go_skip_o  = acc_start || acc_resume;

  if (EXT_FITTED) begin : g_ext
    assign acc_ext = hits_i.ext_sel && (ac_i == EXT_KEY) && !run_i;
  end else begin : g_no_ext
    assign acc_ext = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o    <= '0;
      ptr_hi_o <= '0;
      ptr_lo_o <= '0;
      ext_o    <= 1'b0;
    end else if (hits_i.clear) begin
      cmd_o    <= '0;
      ptr_hi_o <= '0;
      ptr_lo_o <= '0;
      ext_o    <= 1'b0;
    end else begin
      if (acc_load) begin
        cmd_o    <= ac_i;
        ptr_hi_o <= ac_i[HI_W-1:0];
        ext_o    <= 1'b0;
      end else if (acc_ext) begin
        ext_o    <= 1'b1;
      end
      if (acc_start) ptr_lo_o <= ac_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o  <= 1'b0;
      resume_o <= 1'b0;
      reset_o  <= 1'b0;
      ac_clr_o <= 1'b0;
    end else begin
      start_o  <= acc_start;
      resume_o <= acc_resume;
      reset_o  <= hits_i.clear;
      ac_clr_o <= acc_ext;
    end
  end
endmodule

// File: rtl/fhi_flags.sv
module fhi_flags
  import fhi_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  hop_hits_t          hits_i,
  input  logic               exit_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               by_instr_i,
  output logic               irq_o,
  output logic [FLAG_W-1:0]  flags_o,
  output logic               fx_pend_o,
  output logic               ack_o
);
  // flags_o = {unf, eovf, fovf, div0, forced, trap}
  logic forced_nxt;

  assign ack_o      = hits_i.skip_read && irq_o;
  assign forced_nxt = by_instr_i ? 1'b0 : (flags_o[1] || fx_pend_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o     <= 1'b0;
      flags_o   <= '0;
      fx_pend_o <= 1'b0;
    end else if (hits_i.clear) begin
      irq_o     <= 1'b0;
      flags_o   <= '0;
      fx_pend_o <= 1'b0;
    end else begin
      if (hits_i.force_exit) fx_pend_o <= 1'b1;
      if (ack_o) begin
        irq_o   <= 1'b0;
        flags_o <= '0;
      end
      if (exit_i) begin
        irq_o     <= 1'b1;
        flags_o   <= {flags_o[5:2] | cause_i[4:1], forced_nxt, flags_o[0] | cause_i[0]};
        fx_pend_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fpx_host_if.sv
module fpx_host_if
  import fhi_pkg::*;
#(
  parameter int unsigned W          = 12,
  parameter int unsigned HI_W       = 3,
  parameter int unsigned DEV_W      = 6,
  parameter logic [DEV_W-1:0] DEV_MAIN = 6'o55,
  parameter logic [DEV_W-1:0] DEV_AUX  = 6'o56,
  parameter bit          EXT_FITTED = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             iot_valid_i,
  input  logic [DEV_W-1:0] iot_dev_i,
  input  logic [2:0]       iot_op_i,
  input  logic [W-1:0]     ac_i,
  input  logic             core_run_i,
  input  logic             core_pause_i,
  input  logic             core_exit_i,
  input  logic [4:0]       exit_cause_i,
  input  logic             exit_by_instr_i,
  output logic             skip_o,
  output logic             rd_o,
  output logic [W-1:0]     status_o,
  output logic             ac_clr_o,
  output logic [W-1:0]     cmd_o,
  output logic [HI_W-1:0]  ptr_hi_o,
  output logic [W-1:0]     ptr_lo_o,
  output logic             ext_mode_o,
  output logic             start_o,
  output logic             resume_o,
  output logic             reset_o,
  output logic             fexit_req_o,
  output logic             host_int_o
);
  hop_hits_t         hits;
  logic              irq_q, go_skip, ack;
  logic [FLAG_W-1:0] flags;

  fhi_decode #(.DEV_W(DEV_W), .DEV_MAIN(DEV_MAIN), .DEV_AUX(DEV_AUX)) u_dec (
    .valid_i (iot_valid_i),
    .dev_i   (iot_dev_i),
    .op_i    (iot_op_i),
    .hits_o  (hits)
  );

  fhi_cmd_regs #(.W(W), .HI_W(HI_W), .EXT_FITTED(EXT_FITTED)) u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hits_i    (hits),
    .ac_i      (ac_i),
    .run_i     (core_run_i),
    .pause_i   (core_pause_i),
    .irq_i     (irq_q),
    .cmd_o     (cmd_o),
    .ptr_hi_o  (ptr_hi_o),
    .ptr_lo_o  (ptr_lo_o),
    .ext_o     (ext_mode_o),
    .go_skip_o (go_skip),
    .start_o   (start_o),
    .resume_o  (resume_o),
    .reset_o   (reset_o),
    .ac_clr_o  (ac_clr_o)
  );

  fhi_flags u_flg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hits_i     (hits),
    .exit_i     (core_exit_i),
    .cause_i    (exit_cause_i),
    .by_instr_i (exit_by_instr_i),
    .irq_o      (irq_q),
    .flags_o    (flags),
    .fx_pend_o  (fexit_req_o),
    .ack_o      (ack)
  );

  assign skip_o     = (hits.skip_irq && irq_q) || go_skip || ack;
  assign rd_o       = hits.read || ack;
  assign host_int_o = cmd_o[INTE_BIT] && irq_q;

  always_comb begin
    status_o      = '0;
    status_o[11]  = core_run_i;
    status_o[10]  = core_run_i && core_pause_i;
    status_o[9]   = ext_mode_o;
    status_o[6:1] = flags;
    status_o[0]   = cmd_o[FIX_BIT];
  end
endmodule

// File: rtl/fhi_checker.sv
module fhi_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        iot_valid_i,
  input logic [5:0]  iot_dev_i,
  input logic [2:0]  iot_op_i,
  input logic [11:0] ac_i,
  input logic        core_run_i,
  input logic        core_exit_i,
  input logic        irq_q,
  input logic [11:0] cmd_o,
  input logic [11:0] ptr_lo_o,
  input logic        ext_mode_o,
  input logic        start_o,
  input logic        resume_o,
  input logic        fexit_req_o
);
  logic main_v, aux_v;
  assign main_v = iot_valid_i && (iot_dev_i == 6'o55);
  assign aux_v  = iot_valid_i && (iot_dev_i == 6'o56);

  assert_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_v && iot_op_i == 3'd2) |=> (cmd_o == 12'd0 && ptr_lo_o == 12'd0 && !irq_q && !fexit_req_o));

  assert_load_blocked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_v && iot_op_i == 3'd3 && core_run_i) |=> $stable(cmd_o));

  assert_start_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(main_v && iot_op_i == 3'd5 && !core_run_i && !irq_q));

  assert_start_resume_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && resume_o));

  assert_fexit_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_exit_i && !(main_v && iot_op_i == 3'd4)) |=> !fexit_req_o);

  assert_ack_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (main_v && iot_op_i == 3'd7 && irq_q && !core_exit_i) |=> !irq_q);

  assert_ext_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ext_mode_o) |-> $past(aux_v && iot_op_i == 3'd7 && ac_i == 12'o4000 && !core_run_i));
endmodule

bind fpx_host_if fhi_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .iot_valid_i (iot_valid_i),
  .iot_dev_i   (iot_dev_i),
  .iot_op_i    (iot_op_i),
  .ac_i        (ac_i),
  .core_run_i  (core_run_i),
  .core_exit_i (core_exit_i),
  .irq_q       (irq_q),
  .cmd_o       (cmd_o),
  .ptr_lo_o    (ptr_lo_o),
  .ext_mode_o  (ext_mode_o),
  .start_o     (start_o),
  .resume_o    (resume_o),
  .fexit_req_o (fexit_req_o)
);

// File: tb/fpx_host_if_test.sv
module fpx_host_if_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iot_valid = 1'b0;
  logic [5:0]  iot_dev = '0;
  logic [2:0]  iot_op = '0;
  logic [11:0] ac = '0;
  logic        run = 1'b0, pause = 1'b0;
  logic        cexit = 1'b0, by_instr = 1'b0;
  logic [4:0]  cause = '0;
  logic        skip, rd, ac_clr, ext, start, resume, rst_p, fxreq, hint;
  logic [11:0] status, cmd, lo;
  logic [2:0]  hi;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // bench model
  logic [11:0] m_cmd, m_lo;
  logic [2:0]  m_hi;
  logic [5:0]  m_flags;
  logic        m_irq, m_fx, m_ext;

  always #4 clk = ~clk;

  fpx_host_if uut (
    .clk_i(clk), .rst_ni(rst_n), .iot_valid_i(iot_valid), .iot_dev_i(iot_dev),
    .iot_op_i(iot_op), .ac_i(ac), .core_run_i(run), .core_pause_i(pause),
    .core_exit_i(cexit), .exit_cause_i(cause), .exit_by_instr_i(by_instr),
    .skip_o(skip), .rd_o(rd), .status_o(status), .ac_clr_o(ac_clr), .cmd_o(cmd),
    .ptr_hi_o(hi), .ptr_lo_o(lo), .ext_mode_o(ext), .start_o(start),
    .resume_o(resume), .reset_o(rst_p), .fexit_req_o(fxreq), .host_int_o(hint)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [11:0] exp_status();
    return {run, run & pause, m_ext, 2'b00, m_flags, m_cmd[2]};
  endfunction

  task automatic model_clear();
    m_cmd = '0; m_lo = '0; m_hi = '0; m_flags = '0; m_irq = 0; m_fx = 0; m_ext = 0;
  endtask

  task automatic check_state(input string tag);
    chk({"R3 cmd ", tag}, cmd, m_cmd);
    chk({"R3 ptr_hi ", tag}, hi, m_hi);
    chk({"R4 ptr_lo ", tag}, lo, m_lo);
    chk({"R10 ext ", tag}, ext, m_ext);
    chk({"R6 fexit_req ", tag}, fxreq, m_fx);
    chk({"R11 host_int ", tag}, hint, m_cmd[3] & m_irq);
    chk({"R8 status ", tag}, status, exp_status());
  endtask

  task automatic iot(input logic [5:0] d, input logic [2:0] o, input logic [11:0] a);
    logic main, aux, e_skip, e_rd, e_start, e_res, e_rst, e_acc;
    @(negedge clk);
    iot_valid = 1; iot_dev = d; iot_op = o; ac = a;
    #1;
    main = (d == 6'o55); aux = (d == 6'o56);
    e_start = main && o == 5 && !run && !m_irq;
    e_res   = main && o == 5 && run && pause;
    e_rst   = main && o == 2;
    e_acc   = aux && o == 7 && a == 12'o4000 && !run;
    e_skip  = (main && o == 1 && m_irq) || e_start || e_res || (main && o == 7 && m_irq);
    e_rd    = (main && o == 6) || (main && o == 7 && m_irq);
    chk("R2 R5 R9 skip", skip, e_skip);
    chk("R8 R9 rd", rd, e_rd);
    chk("R8 R9 status before edge", status, exp_status());
    if (!main && !aux) chk("R12 foreign device no skip", skip | rd, 0);
    if (main && o == 2) model_clear();
    if (main && o == 3 && !run && !m_irq) begin m_cmd = a; m_hi = a[2:0]; m_ext = 0; end
    if (main && o == 4) m_fx = 1;
    if (e_start) m_lo = a;
    if (main && o == 7 && m_irq) begin m_irq = 0; m_flags = '0; end
    if (e_acc) m_ext = 1;
    @(negedge clk);
    iot_valid = 0;
    #1;
    chk("R4 start pulse", start, e_start);
    chk("R5 resume pulse", resume, e_res);
    chk("R1 reset pulse", rst_p, e_rst);
    chk("R10 ac clear pulse", ac_clr, e_acc);
    check_state("after iot");
  endtask

  task automatic core_exit(input logic [4:0] c, input logic bi);
    @(negedge clk);
    cexit = 1; cause = c; by_instr = bi;
    @(negedge clk);
    cexit = 0;
    m_irq = 1;
    m_flags = {m_flags[5:2] | c[4:1], bi ? 1'b0 : (m_flags[1] | m_fx), m_flags[0] | c[0]};
    m_fx = 0;
    #1;
    check_state("R7 after exit");
  endtask

  task automatic set_core(input logic r, input logic p);
    @(negedge clk);
    run = r; pause = p;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main_seq
    void'($urandom(32'h5eed1));
    model_clear();
    repeat (3) @(negedge clk);
    #1;
    check_state("R1 reset state");
    chk("R1 no pulses at reset", {start, resume, rst_p, ac_clr}, 0);
    rst_n = 1;

    // directed: load and start while idle
    iot(6'o55, 3, 12'o0017);
    iot(6'o55, 5, 12'o1234);
    // directed: exit with forced request, then normal-instruction exit clears forced bit
    iot(6'o55, 4, 0);
    core_exit(5'b00010, 1'b0);
    iot(6'o55, 3, 12'o7777);          // blocked by pending request (R3)
    iot(6'o55, 1, 0);                 // R2 skip
    iot(6'o55, 4, 0);
    core_exit(5'b00000, 1'b1);        // R6 forced bit cleared
    iot(6'o55, 7, 0);                 // R9 ack
    iot(6'o55, 7, 0);                 // R9 no request: nothing
    // directed: wide mode gating
    set_core(1, 0);
    iot(6'o56, 7, 12'o4000);          // R10 refused while running
    set_core(0, 0);
    iot(6'o56, 7, 12'o4001);          // R10 wrong key
    iot(6'o56, 7, 12'o4000);          // R10 accepted
    iot(6'o55, 3, 12'o0000);          // R3 load drops wide mode
    set_core(1, 1);
    iot(6'o55, 5, 12'o5555);          // R5 resume
    iot(6'o55, 2, 0);                 // R1 clear
    set_core(0, 0);

    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom % 10;
      if (r < 6) begin
        logic [5:0] d;
        logic [11:0] a;
        int unsigned s;
        s = $urandom % 10;
        d = (s < 7) ? 6'o55 : (s < 9) ? 6'o56 : 6'($urandom);
        a = ($urandom % 4 == 0) ? 12'o4000 : 12'($urandom);
        iot(d, 3'($urandom), a);
      end else if (r < 8) begin
        core_exit(5'($urandom), 1'($urandom));
      end else begin
        logic rr;
        rr = ($urandom % 3 == 0);
        set_core(rr, rr & 1'($urandom));
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule